// File: doc/BRIEF.md
# Two-Byte Batching Stream Buffer

This block sits between a byte-wide producer stream and a byte-wide consumer stream that run on the same clock. It gathers exactly two bytes from the producer into a pair of holding slots. While it gathers, the consumer side reports empty. Once both slots are filled, the block raises full toward the producer and offers the two bytes to the consumer, the earlier byte first.

When the consumer has taken the second byte, the block returns to gathering. Unlike a FIFO, no byte is released before its partner has arrived, and no new byte is taken until the whole pair has drained. Read data is presented combinationally, in the manner of a first-word-fall-through FIFO. Each side supplies an "open" level. While neither side is open, the block is held in its reset state and drops any half-gathered pair.

Top module: `pair_batch_buf`

## Requirements
- R1: After synchronous active-low reset, wr_full is 0, rd_empty is 1 and rd_data is 0.
- R2: A byte is taken only on a rising edge where wr_en is 1 and wr_full is 0. The first byte taken goes to slot 0 and the second to slot 1. After the first byte, wr_full stays 0 and rd_empty stays 1. From the edge that takes the second byte, wr_full is 1 and rd_empty is 0.
- R3: While rd_empty is 0, rd_data shows slot 0 until one read is taken, then slot 1, so bytes leave in arrival order.
- R4: rd_data is valid without any read strobe whenever rd_empty is 0, and reads 0 whenever rd_empty is 1.
- R5: wr_en asserted while wr_full is 1 has no effect: the held pair is neither overwritten nor extended.
- R6: rd_en asserted while rd_empty is 1 has no effect: gathering continues and no byte is skipped.
- R7: The edge where rd_en is 1 while slot 1 is presented returns the block to gathering: wr_full is 0 and rd_empty is 1 from that edge on.
- R8: rd_eof is 1 exactly when rd_empty is 1 and wr_open is 0.
- R9: On any edge where wr_open and rd_open are both 0, the block returns to its reset state and discards a partly gathered pair. If either side is open, the block operates normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both streams |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_open | input | 1 | Producer stream is open |
| wr_en | input | 1 | Producer offers wr_data this cycle |
| wr_data | input | DATA_W | Producer byte |
| wr_full | output | 1 | Producer must hold off |
| rd_open | input | 1 | Consumer stream is open |
| rd_en | input | 1 | Consumer takes rd_data this cycle |
| rd_data | output | DATA_W | Presented byte, valid while rd_empty is 0 |
| rd_empty | output | 1 | Nothing to present |
| rd_eof | output | 1 | Nothing to present and producer closed |

## Verification
The hardest situation to reach is a session close that lands while one byte has been gathered and its partner has not. It can only be seen afterwards, because the stale byte would appear as the first byte of the next pair. The bench writes a single byte, drops both open levels for one cycle, reopens them and sends a fresh pair, then checks that the fresh first byte comes out first. A producer that keeps wr_en high across three cycles covers the blocked-write case: the third byte must not disturb the pair already held.

// File: rtl/pair_batch_pkg.sv
// Package: shared types for the two-byte batching buffer.
// Assumes: exactly two holding slots; state order is not decoded elsewhere.
package pair_batch_pkg;

    // Phase of the gather / release cycle.
    typedef enum logic [1:0] {
        ST_FILL_0 = 2'd0,   // waiting for the first byte
        ST_FILL_1 = 2'd1,   // waiting for the second byte
        ST_SEND_0 = 2'd2,   // presenting the first byte
        ST_SEND_1 = 2'd3    // presenting the second byte
    } pair_state_e;

    // Number of holding slots in one batch.
    localparam int unsigned PAIR_SLOTS = 2;

    // True while the block releases bytes to the consumer.
    function automatic logic is_sending(input pair_state_e s);
        return (s == ST_SEND_0) || (s == ST_SEND_1);
    endfunction

endpackage

// File: rtl/pair_seq.sv
// Module: pair_seq
// Sequences one batch: gather slot 0, gather slot 1, release slot 0,
// release slot 1, repeat. It drives the only copies of full and empty.
// Assumes: sess_clr is a synchronous clear that ranks below rst_n.
module pair_seq
    import pair_batch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sess_clr,
    input  logic        wr_en,
    input  logic        rd_en,
    output pair_state_e state,
    output logic        load_0,
    output logic        load_1,
    output logic        full,
    output logic        empty
);

    pair_state_e state_nxt;
    logic        take;
    logic        give;

    // Handshake qualifiers: a transfer happens only when the flag permits it.
    always_comb begin
        full  = is_sending(state);
        empty = !is_sending(state);
        take  = wr_en && !full;
        give  = rd_en && !empty;
    end

    // Slot load strobes toward the holding registers.
    always_comb begin
        load_0 = take && (state == ST_FILL_0);
        load_1 = take && (state == ST_FILL_1);
    end

    // Next phase of the batch.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FILL_0: if (take) state_nxt = ST_FILL_1;
            ST_FILL_1: if (take) state_nxt = ST_SEND_0;
            ST_SEND_0: if (give) state_nxt = ST_SEND_1;
            ST_SEND_1: if (give) state_nxt = ST_FILL_0;
            default:             state_nxt = ST_FILL_0;
        endcase
    end

    // Phase register with reset and session clear.
    always_ff @(posedge clk) begin
        if (!rst_n || sess_clr) state <= ST_FILL_0;
        else                    state <= state_nxt;
    end

endmodule

// File: rtl/pair_hold.sv
// Module: pair_hold
// Holds the two bytes of a batch and selects the one being presented.
// Assumes: load strobes are one-hot or idle; state comes from pair_seq.
module pair_hold
    import pair_batch_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_clr,
    input  logic              load_0,
    input  logic              load_1,
    input  logic [DATA_W-1:0] wr_data,
    input  pair_state_e       state,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned NSLOT = PAIR_SLOTS;

    logic [NSLOT-1:0]  load_vec;
    logic [DATA_W-1:0] slot_q [NSLOT];

    // Gather the per-slot load strobes into one vector.
    always_comb load_vec = {load_1, load_0};

    // One holding register per slot.
    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
        // Capture the producer byte into this slot when its strobe fires.
        always_ff @(posedge clk) begin
            if (!rst_n || sess_clr) slot_q[gi] <= '0;
            else if (load_vec[gi])  slot_q[gi] <= wr_data;
        end
    end

    // Present the slot matching the release phase, zero while gathering.
    always_comb begin
        unique case (state)
            ST_SEND_0: rd_data = slot_q[0];
            ST_SEND_1: rd_data = slot_q[1];
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pair_batch_buf.sv
// Module: pair_batch_buf (top)
// Two-byte batching buffer between a producer and a consumer stream on
// one clock. Gathers two bytes, then releases them in order.
// Assumes: both streams share clk; rst_n is synchronous, active low.
module pair_batch_buf
    import pair_batch_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_open,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_open,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_eof
);

    pair_state_e state;
    logic        sess_clr;
    logic        load_0;
    logic        load_1;
    logic        full_i;
    logic        empty_i;

    // Session clear while neither stream is open.
    always_comb sess_clr = !wr_open && !rd_open;

    pair_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sess_clr (sess_clr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .state    (state),
        .load_0   (load_0),
        .load_1   (load_1),
        .full     (full_i),
        .empty    (empty_i)
    );

    pair_hold #(.DATA_W(DATA_W)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .sess_clr (sess_clr),
        .load_0   (load_0),
        .load_1   (load_1),
        .wr_data  (wr_data),
        .state    (state),
        .rd_data  (rd_data)
    );

    // Single driver for each handshake output.
    always_comb begin
        wr_full  = full_i;
        rd_empty = empty_i;
        rd_eof   = empty_i && !wr_open;
    end

endmodule

// File: rtl/pair_batch_buf_chk.sv
// Module: pair_batch_buf_chk
// Port-level properties of pair_batch_buf, attached with bind below.
// Assumes: the same clk and rst_n as the buffer.
module pair_batch_buf_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_open,
    input logic              wr_en,
    input logic              wr_full,
    input logic              rd_open,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_empty,
    input logic              rd_eof
);

    // R2: full can only rise after a write was offered while not full.
    assert_full_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_full) |-> $past(wr_en && !wr_full));

    // R5: the presented byte holds while nothing is read and the session stays open.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_empty && !rd_en && (wr_open || rd_open)) |=> $stable(rd_data));

    // R6: a read strobe with nothing to present and no write leaves the buffer empty.
    assert_empty_read_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && rd_en && !wr_en) |=> rd_empty);

    // R7: full falls only after a read, or after a session close.
    assert_drain_by_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_full) |-> $past(rd_en || (!wr_open && !rd_open)));

    // R8: end of file is only reported while nothing is presented.
    assert_eof_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_eof |-> (rd_empty && !wr_open));

    // R9: with both streams closed, the next cycle is idle gathering.
    assert_closed_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_open && !rd_open) |=> (!wr_full && rd_empty));

endmodule

bind pair_batch_buf pair_batch_buf_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_open  (wr_open),
    .wr_en    (wr_en),
    .wr_full  (wr_full),
    .rd_open  (rd_open),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_empty (rd_empty),
    .rd_eof   (rd_eof)
);

// File: tb/test_pair_batch_buf.sv
// Directed bench for pair_batch_buf: one task per scenario.
module test_pair_batch_buf;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_open = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_open = 1'b1;
    logic          rd_en = 1'b0;
    logic          wr_full;
    logic [DW-1:0] rd_data;
    logic          rd_empty;
    logic          rd_eof;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    pair_batch_buf #(.DATA_W(DW)) i_pair_batch_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_open(wr_open), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_open(rd_open), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_eof(rd_eof)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one byte for one cycle; sample at the following falling edge.
    task automatic put(input logic [DW-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic take();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 full", wr_full, 0);
        check("R1 empty", rd_empty, 1);
        check("R4 data zero when empty", rd_data, 0);
        check("R8 eof with writer open", rd_eof, 0);
    endtask

    task automatic t_pair(input logic [DW-1:0] a, input logic [DW-1:0] b);
        put(a);
        check("R2 one byte held, not full", wr_full, 0);
        check("R2 one byte held, still empty", rd_empty, 1);
        put(b);
        check("R2 pair held, full", wr_full, 1);
        check("R2 pair held, not empty", rd_empty, 0);
        check("R3 first byte presented", rd_data, a);
        take();
        check("R3 second byte presented", rd_data, b);
        check("R4 still valid", rd_empty, 0);
        take();
        check("R7 back to gathering full", wr_full, 0);
        check("R7 back to gathering empty", rd_empty, 1);
    endtask

    task automatic t_write_blocked();
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h11;
        @(negedge clk); wr_data = 8'h22;
        @(negedge clk); wr_data = 8'h33;   // arrives while full
        @(negedge clk); wr_en = 1'b0;
        check("R5 full after pair", wr_full, 1);
        check("R5 first byte kept", rd_data, 8'h11);
        take();
        check("R5 second byte kept", rd_data, 8'h22);
        take();
        check("R5 blocked byte not gathered", rd_empty, 1);
    endtask

    task automatic t_read_when_empty();
        take();
        check("R6 read on empty ignored", rd_empty, 1);
        put(8'h5A);
        take();
        check("R6 read mid-gather ignored", wr_full, 0);
        put(8'hA5);
        check("R6 first byte intact", rd_data, 8'h5A);
        take();
        check("R6 second byte intact", rd_data, 8'hA5);
        take();
    endtask

    task automatic t_eof();
        @(negedge clk); wr_open = 1'b0;
        #1 check("R8 eof when empty and writer closed", rd_eof, 1);
        @(negedge clk); wr_open = 1'b1;
        put(8'hC1); put(8'hC2);
        @(negedge clk); wr_open = 1'b0;
        #1 check("R8 no eof while presenting", rd_eof, 0);
        check("R9 reader open keeps pair", rd_data, 8'hC1);
        take();
        check("R9 reader open keeps second", rd_data, 8'hC2);
        take();
        check("R8 eof after drain", rd_eof, 1);
        @(negedge clk); wr_open = 1'b1;
    endtask

    task automatic t_close();
        put(8'hEE);
        @(negedge clk); wr_open = 1'b0; rd_open = 1'b0;
        @(negedge clk); wr_open = 1'b1; rd_open = 1'b1;
        check("R9 closed clears full", wr_full, 0);
        put(8'h71);
        check("R9 stale byte discarded", rd_empty, 1);
        put(8'h72);
        check("R9 fresh first byte", rd_data, 8'h71);
        take();
        check("R9 fresh second byte", rd_data, 8'h72);
        take();
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pair(8'h4A, 8'h6F);
        t_pair(8'h68, 8'h6E);
        t_write_blocked();
        t_read_when_empty();
        t_eof();
        t_close();
        t_pair(8'hFF, 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule